// File: doc/BRIEF.md
# Host Word-Stream Program Loader

This block fills program RAM from a stream of 24-bit words delivered by a host-side port, such as a parallel host port or a serial slave that has already assembled whole words. Words arrive over a valid/ready handshake. The first word taken is a word count and the second is a load address. Each word after that is written to program RAM at consecutive addresses, beginning at the load address. When the last counted word has been taken, the block raises a one-cycle start request and presents the load address as the execution vector.

The host can also end loading early by raising a stop flag. Once the load address is known, the flag ends the transfer and issues the start request at once. Before that point there is no vector, so the flag has no effect. After the start request the block refuses all input until the next reset. Bus and serial protocol decoding happen upstream, so only the word stream and the flag enter this block.

Top module: `word_stream_boot_loader`

## Requirements
- R1: After reset `in_ready_o` is 1, and `ram_we_o` and `start_o` are both 0.
- R2: The first word taken (valid and ready both high at a rising edge) is the data word count, using all 24 bits. The second word taken is the load address. Only its low ADDR_W bits (default 16) are used.
- R3: Each data word taken is written one cycle later. In that cycle `ram_we_o` is 1 for a single cycle, `ram_data_o` carries the word, and `ram_addr_o` is the load address plus the word's index, counting from 0.
- R4: When the counted number of data words has been taken, `start_o` is 1 for exactly one cycle. That cycle is the one after the last word was taken, and `start_addr_o` then equals the load address.
- R5: A word count of zero raises `start_o` in the cycle after the address word is taken, and no RAM write occurs.
- R6: During the data phase, a high `stop_flag_i` forces `in_ready_o` to 0 in that same cycle, so no word is taken. `start_o` follows in the next cycle, with the load address on `start_addr_o`.
- R7: `stop_flag_i` has no effect while the count or the address word is still awaited. `in_ready_o` stays 1 and both header words are taken normally.
- R8: From the start request onward, `in_ready_o` stays 0 and no RAM write happens until reset.
- R9: A cycle with `in_valid_i` low takes no word and produces no RAM write in the following cycle.
- R10: The RAM write address wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Host word valid |
| in_word_i | input | 24 | Host word |
| in_ready_o | output | 1 | Block can take a word this cycle |
| stop_flag_i | input | 1 | Host flag that ends loading early |
| ram_we_o | output | 1 | Program RAM write strobe |
| ram_addr_o | output | ADDR_W | Program RAM write address |
| ram_data_o | output | 24 | Program RAM write data |
| start_o | output | 1 | One-cycle execution start request |
| start_addr_o | output | ADDR_W | Execution start vector (load address) |

## Verification
`in_ready_o` is combinational, including its response to the stop flag, so the bench samples it just after driving inputs on the falling edge, before the edge that could take the word. The RAM write and the start request come from registers and are due one rising edge after the accepting edge. The bench therefore checks them shortly after that edge, before it drives the next word. The post-start lockout is checked both in the cycle after the pulse and after a further word is offered.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  typedef enum logic [2:0] {
    ST_COUNT  = 3'd0,
    ST_ADDR   = 3'd1,
    ST_DATA   = 3'd2,
    ST_LAUNCH = 3'd3,
    ST_HALT   = 3'd4
  } wsl_state_e;
endpackage

// File: rtl/wsl_seq.sv
module wsl_seq
  import wsl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              stop_flag_i,
  output logic              in_ready_o,
  output logic              acc_addr_o,
  output logic              acc_data_o,
  output logic              launch_o
);

  function automatic logic is_last(input logic [WORD_W-1:0] rem);
    return rem == WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] count_down(input logic [WORD_W-1:0] rem);
    return rem - WORD_W'(1);
  endfunction

  wsl_state_e        state_q, state_d;
  logic [WORD_W-1:0] remain_q;

  // named internal events
  logic take, acc_cnt, stop_hit, last_hit, empty_load;

  assign in_ready_o = (state_q == ST_COUNT) || (state_q == ST_ADDR) ||
                      ((state_q == ST_DATA) && !stop_flag_i);
  assign take       = in_valid_i && in_ready_o;
  assign acc_cnt    = take && (state_q == ST_COUNT);
  assign acc_addr_o = take && (state_q == ST_ADDR);
  assign acc_data_o = take && (state_q == ST_DATA);
  assign stop_hit   = (state_q == ST_DATA) && stop_flag_i;
  assign last_hit   = acc_data_o && is_last(remain_q);
  assign empty_load = acc_addr_o && (remain_q == '0);
  assign launch_o   = (state_q == ST_LAUNCH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COUNT:  if (acc_cnt) state_d = ST_ADDR;
      ST_ADDR:   if (acc_addr_o) state_d = empty_load ? ST_LAUNCH : ST_DATA;
      ST_DATA:   if (stop_hit || last_hit) state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_COUNT;
      remain_q <= '0;
    end else begin
      state_q <= state_d;
      if (acc_cnt)         remain_q <= in_word_i;
      else if (acc_data_o) remain_q <= count_down(remain_q);
    end
  end

  assert_flag_ignored_early_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_COUNT || state_q == ST_ADDR) && stop_flag_i && !in_valid_i)
      |=> (state_q == $past(state_q)));

  assert_stop_launches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit |=> launch_o);

  assert_zero_count_launch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_load |=> (launch_o && !acc_data_o));

  assert_start_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  assert_locked_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (!in_ready_o && !acc_data_o));

endmodule

// File: rtl/wsl_wr_stage.sv
module wsl_wr_stage #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_addr_i,
  input  logic              acc_data_i,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_data_o,
  output logic [ADDR_W-1:0] start_addr_o
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] vec_of(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] base_q, ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      ptr_q      <= '0;
      ram_we_o   <= 1'b0;
      ram_addr_o <= '0;
      ram_data_o <= '0;
    end else begin
      ram_we_o <= acc_data_i;
      if (acc_addr_i) begin
        base_q <= vec_of(in_word_i);
        ptr_q  <= vec_of(in_word_i);
      end
      if (acc_data_i) begin
        ram_addr_o <= ptr_q;
        ram_data_o <= in_word_i;
        ptr_q      <= addr_step(ptr_q);
      end
    end
  end

  assign start_addr_o = base_q;

  assert_write_follows_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_data_i |=> (ram_we_o && ram_data_o == $past(in_word_i)));

  assert_first_write_at_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_addr_i |=> (start_addr_o == $past(in_word_i[ADDR_W-1:0])));

  assert_consecutive_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && acc_data_i) |=> (ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  assert_no_idle_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_data_i |=> !ram_we_o);

endmodule

// File: rtl/word_stream_boot_loader.sv
module word_stream_boot_loader #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              in_ready_o,
  input  logic              stop_flag_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_data_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o
);

  localparam int VecW = (ADDR_W < WORD_W) ? ADDR_W : WORD_W;

  logic acc_addr, acc_data;

  wsl_seq #(.WORD_W(WORD_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_word_i   (in_word_i),
    .stop_flag_i (stop_flag_i),
    .in_ready_o  (in_ready_o),
    .acc_addr_o  (acc_addr),
    .acc_data_o  (acc_data),
    .launch_o    (start_o)
  );

  wsl_wr_stage #(.WORD_W(WORD_W), .ADDR_W(VecW)) i_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_addr_i   (acc_addr),
    .acc_data_i   (acc_data),
    .in_word_i    (in_word_i),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_data_o   (ram_data_o),
    .start_addr_o (start_addr_o)
  );

  assert_start_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !in_ready_o);

  assert_start_vector_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> $stable(start_addr_o));

endmodule

// File: tb/test_word_stream_boot_loader.sv
module test_word_stream_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  localparam int V_CNT [NV] = '{3, 5, 0, 6, 4, 4, 32'h010002};
  localparam int V_ADR [NV] = '{32'h000100, 32'h7F0040, 32'h001234, 32'h000200,
                                32'hABFFFE, 32'h000300, 32'h000777};
  localparam int V_STP [NV] = '{-1, -1, -1, 2, -1, 0, 3};
  localparam int V_GAP [NV] = '{0, 1, 0, 0, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_word = '0;
  logic        in_ready;
  logic        stop_flag = 1'b0;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [23:0] ram_data;
  logic        start;
  logic [15:0] start_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  word_stream_boot_loader i_word_stream_boot_loader (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .in_word_i (in_word),
    .in_ready_o (in_ready), .stop_flag_i (stop_flag), .ram_we_o (ram_we),
    .ram_addr_o (ram_addr), .ram_data_o (ram_data), .start_o (start),
    .start_addr_o (start_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] dword(input int v, input int i);
    return 24'h5A0000 ^ 24'(v << 12) ^ 24'(i * 37);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; stop_flag = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a word at the falling edge, check ready, let one rising edge pass,
  // return shortly after that edge with valid low
  task automatic push(input logic [23:0] w, input logic exp_rdy, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    #1;
    chk(req, "in_ready", 32'(in_ready), 32'(exp_rdy));
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic idle_cycle(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    chk(req, "ram_we idle", 32'(ram_we), 32'd0);
  endtask

  task automatic lock_check(input logic [15:0] vec);
    @(posedge clk); #2;
    chk("R8", "start after pulse", 32'(start), 32'd0);
    chk("R8", "ready after start", 32'(in_ready), 32'd0);
    push(24'hDEAD01, 1'b0, "R8");
    @(posedge clk); #2;
    chk("R8", "no write after start", 32'(ram_we), 32'd0);
    chk("R8", "vector held", 32'(start_addr), 32'(vec));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #3;
    chk("R1", "ready in reset", 32'(in_ready), 32'd1);
    chk("R1", "we in reset", 32'(ram_we), 32'd0);
    chk("R1", "start in reset", 32'(start), 32'd0);
    do_reset();
    #1;
    chk("R1", "ready after reset", 32'(in_ready), 32'd1);

    for (int v = 0; v < NV; v++) begin
      int cnt, nw;
      logic [15:0] base;
      cnt  = V_CNT[v];
      base = V_ADR[v][15:0];
      nw   = (V_STP[v] < 0) ? cnt : V_STP[v];
      do_reset();
      push(24'(cnt), 1'b1, "R2");
      chk("R2", "no write after count", 32'(ram_we), 32'd0);
      chk("R2", "no start after count", 32'(start), 32'd0);
      push(24'(V_ADR[v]), 1'b1, "R2");
      chk("R2", "no write after addr", 32'(ram_we), 32'd0);
      if (cnt == 0) begin
        chk("R5", "start on zero count", 32'(start), 32'd1);
        chk("R5", "vector on zero count", 32'(start_addr), 32'(base));
        lock_check(base);
        continue;
      end
      chk("R2", "no start after addr", 32'(start), 32'd0);
      for (int i = 0; i < nw; i++) begin
        if (V_GAP[v] != 0) idle_cycle("R9");
        push(dword(v, i), 1'b1, "R3");
        chk("R3", "we", 32'(ram_we), 32'd1);
        chk("R10", "addr", 32'(ram_addr), 32'(16'(base + 16'(i))));
        chk("R3", "data", 32'(ram_data), 32'(dword(v, i)));
        if (V_STP[v] < 0 && i == cnt - 1) begin
          chk("R4", "start at last word", 32'(start), 32'd1);
          chk("R4", "start vector", 32'(start_addr), 32'(base));
        end else begin
          chk("R4", "no early start", 32'(start), 32'd0);
        end
      end
      if (V_STP[v] >= 0) begin
        @(negedge clk);
        stop_flag = 1'b1; in_valid = 1'b1; in_word = 24'hBAD000;
        #1;
        chk("R6", "ready under stop", 32'(in_ready), 32'd0);
        @(posedge clk); #2;
        stop_flag = 1'b0; in_valid = 1'b0;
        chk("R6", "start after stop", 32'(start), 32'd1);
        chk("R6", "no write under stop", 32'(ram_we), 32'd0);
        chk("R6", "stop vector", 32'(start_addr), 32'(base));
      end
      lock_check(base);
    end

    // R7: flag held high through both header words is ignored
    do_reset();
    @(negedge clk); stop_flag = 1'b1;
    @(posedge clk); #2;
    chk("R7", "no start on early flag", 32'(start), 32'd0);
    push(24'd2, 1'b1, "R7");
    chk("R7", "no start after count", 32'(start), 32'd0);
    push(24'h000050, 1'b1, "R7");
    stop_flag = 1'b0;
    chk("R7", "no start after addr", 32'(start), 32'd0);
    push(24'h111111, 1'b1, "R7");
    chk("R7", "write addr", 32'(ram_addr), 32'h50);
    push(24'h222222, 1'b1, "R7");
    chk("R7", "second write addr", 32'(ram_addr), 32'h51);
    chk("R7", "start after full load", 32'(start), 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule